// File: doc/BRIEF.md
# Rolling-Key Bus Scrambler Pair

This block is a matched pair of masking lanes placed around a stretch of data path that only forwards words and never computes on them, such as the hop from a cache to a memory controller. The transmit lane XORs every accepted word with a 32-bit key drawn from an xorshift generator. The untrusted forwarding logic in the middle therefore only ever sees masked values. The receive lane holds an identical generator and XORs each word it hands on with its own copy of the key, which recovers the original word.

Each generator steps exactly once per accepted transfer on its own side. The mask on the bus therefore changes with every beat, and no fixed trigger pattern can be planted on the bus at a chosen time. Stalls, backpressure and latency inside the middle stage do not move the two generators out of step, provided the middle stage delivers words in order and drops none. Both lanes restart from a shared seed on a load strobe. A zero seed would freeze an xorshift generator, so a zero seed is replaced by a fixed non-zero constant.

Top module: `bus_scrambler_pair`

## Requirements
- R1: After reset both generators hold the fallback key 32'h2545F491, so the first word accepted after reset leaves as its plaintext XOR 32'h2545F491.
- R2: `scr_data_o` always equals `src_data_i` XOR the current transmit key. `scr_valid_o` follows `src_valid_i`, and `src_ready_o` follows `scr_ready_i` outside seed-load cycles.
- R3: The key sequence is 32-bit xorshift: x ^= x << 13, then x ^= x >> 17, then x ^= x << 5. Each lane applies one step at the clock edge that ends a cycle with an accepted transfer on its side.
- R4: A lane's key does not change over a cycle without an accepted transfer on its side, whatever stall pattern is present.
- R5: `dst_data_o` equals `mid_data_i` XOR the current receive key. The stream accepted at the destination equals the stream accepted at the source, word for word and in order, for any in-order middle-stage delay and any stalls.
- R6: A cycle with `seed_load_i` high loads `seed_i` into both generators. A zero seed loads 32'h2545F491 instead.
- R7: In a cycle with `seed_load_i` high, `src_ready_o` and `mid_ready_o` are low, so no transfer is accepted on either side.
- R8: `dst_valid_o` follows `mid_valid_i`, and `mid_ready_o` follows `dst_ready_i` outside seed-load cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seed_load_i | input | 1 | Load strobe for both generators |
| seed_i | input | 32 | Shared seed value |
| src_valid_i | input | 1 | Plaintext word valid from the source |
| src_data_i | input | 32 | Plaintext word from the source |
| src_ready_o | output | 1 | Transmit lane can accept |
| scr_valid_o | output | 1 | Masked word valid toward the middle stage |
| scr_data_o | output | 32 | Masked word toward the middle stage |
| scr_ready_i | input | 1 | Middle stage accepts a masked word |
| mid_valid_i | input | 1 | Masked word valid from the middle stage |
| mid_data_i | input | 32 | Masked word from the middle stage |
| mid_ready_o | output | 1 | Receive lane can accept |
| dst_valid_o | output | 1 | Recovered word valid |
| dst_data_o | output | 32 | Recovered plaintext word |
| dst_ready_i | input | 1 | Destination accepts a recovered word |

## Verification
The bench goes after stalls on each side separately. Stalls on the source side and backpressure on the destination side are random and independent, and a queue holds a variable number of words in flight in the middle. A lane that stepped on valid alone, without waiting for the handshake, would drift out of step, and every later recovered word would be garbage. The bench reloads the seed with both a non-zero value and zero. A design that kept a zero seed would emit plaintext unmasked from then on, and one that loaded only one lane would break recovery at once. The bench also holds traffic pending while the seed is loaded. A lane that still accepted a word during the load would mask that word with a key the far end never uses.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int unsigned KeyW = 32;
  localparam int unsigned ShA = 13;
  localparam int unsigned ShB = 17;
  localparam int unsigned ShC = 5;
  localparam logic [KeyW-1:0] FallbackKey = 32'h2545_F491;

  typedef logic [KeyW-1:0] key_t;
endpackage

// File: rtl/xorshift_gen.sv
module xorshift_gen #(
  parameter int unsigned W = 32,
  parameter int unsigned SH_A = 13,
  parameter int unsigned SH_B = 17,
  parameter int unsigned SH_C = 5,
  parameter logic [W-1:0] FALLBACK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] key_o
);
  logic [W-1:0] state_q, s1, s2, s3, seed_fix;

  always_comb begin
    s1 = state_q ^ (state_q << SH_A);
    s2 = s1 ^ (s1 >> SH_B);
    s3 = s2 ^ (s2 << SH_C);
    seed_fix = (seed_i == '0) ? FALLBACK : seed_i;
  end

  // load has priority; a load cycle never carries a transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= FALLBACK;
    else if (load_i) state_q <= seed_fix;
    else if (step_i) state_q <= s3;
  end

  assign key_o = state_q;
endmodule

// File: rtl/mask_lane.sv
module mask_lane
  import bsp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  key_t  seed_i,
  input  logic  in_valid_i,
  input  key_t  in_data_i,
  output logic  in_ready_o,
  output logic  out_valid_o,
  output key_t  out_data_o,
  input  logic  out_ready_i,
  output key_t  key_o
);
  logic fire;
  key_t key;

  assign in_ready_o  = out_ready_i & ~load_i;
  assign out_valid_o = in_valid_i;
  assign out_data_o  = in_data_i ^ key;
  assign fire        = in_valid_i & out_ready_i & ~load_i;
  assign key_o       = key;

  xorshift_gen #(
    .W(KeyW), .SH_A(ShA), .SH_B(ShB), .SH_C(ShC), .FALLBACK(FallbackKey)
  ) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .seed_i(seed_i),
    .step_i(fire), .key_o(key)
  );
endmodule

// File: rtl/bus_scrambler_pair.sv
module bus_scrambler_pair
  import bsp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            seed_load_i,
  input  logic [KeyW-1:0] seed_i,
  input  logic            src_valid_i,
  input  logic [KeyW-1:0] src_data_i,
  output logic            src_ready_o,
  output logic            scr_valid_o,
  output logic [KeyW-1:0] scr_data_o,
  input  logic            scr_ready_i,
  input  logic            mid_valid_i,
  input  logic [KeyW-1:0] mid_data_i,
  output logic            mid_ready_o,
  output logic            dst_valid_o,
  output logic [KeyW-1:0] dst_data_o,
  input  logic            dst_ready_i
);
  key_t tx_key, rx_key;

  mask_lane u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(seed_load_i), .seed_i(seed_i),
    .in_valid_i(src_valid_i), .in_data_i(src_data_i), .in_ready_o(src_ready_o),
    .out_valid_o(scr_valid_o), .out_data_o(scr_data_o), .out_ready_i(scr_ready_i),
    .key_o(tx_key)
  );

  mask_lane u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(seed_load_i), .seed_i(seed_i),
    .in_valid_i(mid_valid_i), .in_data_i(mid_data_i), .in_ready_o(mid_ready_o),
    .out_valid_o(dst_valid_o), .out_data_o(dst_data_o), .out_ready_i(dst_ready_i),
    .key_o(rx_key)
  );
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        seed_load_i,
  input logic        src_valid_i,
  input logic        src_ready_o,
  input logic        mid_valid_i,
  input logic        mid_ready_o,
  input logic [31:0] tx_key,
  input logic [31:0] rx_key
);
  logic [31:0] tx_cnt, rx_cnt;
  logic tx_fire, rx_fire;

  assign tx_fire = src_valid_i & src_ready_o;
  assign rx_fire = mid_valid_i & mid_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else if (seed_load_i) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else begin
      tx_cnt <= tx_cnt + 32'(tx_fire);
      rx_cnt <= rx_cnt + 32'(rx_fire);
    end
  end

  assert_no_accept_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |-> (!src_ready_o && !mid_ready_o));

  assert_key_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_key != '0) && (rx_key != '0));

  assert_hold_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_fire && !seed_load_i) |=> $stable(tx_key));

  assert_step_on_fire_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fire && !seed_load_i) |=> (tx_key != $past(tx_key)));

  assert_lanes_in_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt == rx_cnt) |-> (tx_key == rx_key));
endmodule

bind bus_scrambler_pair bsp_checker u_bsp_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .seed_load_i(seed_load_i),
  .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
  .mid_valid_i(mid_valid_i), .mid_ready_o(mid_ready_o),
  .tx_key(tx_key), .rx_key(rx_key)
);

// File: tb/bus_scrambler_pair_bench.sv
module bus_scrambler_pair_bench;
  localparam logic [31:0] K0 = 32'h2545_F491;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic seed_load_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic src_valid_i = 1'b0, scr_ready_i = 1'b0, mid_valid_i = 1'b0, dst_ready_i = 1'b0;
  logic [31:0] src_data_i = '0, mid_data_i = '0;
  logic src_ready_o, scr_valid_o, mid_ready_o, dst_valid_o;
  logic [31:0] scr_data_o, dst_data_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] tx_k = K0, rx_k = K0;
  logic [31:0] midq[$];
  logic [31:0] expq[$];

  always #5 clk = ~clk;

  bus_scrambler_pair u_bus_scrambler_pair (.*, .clk_i(clk));

  function automatic logic [31:0] nxt(logic [31:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(bit allow_src, bit load, logic [31:0] sd);
    bit sf, mf, rdy_s, rdy_m;
    @(negedge clk);
    seed_load_i = load;
    seed_i      = sd;
    src_valid_i = allow_src && ($urandom % 4 != 0);
    src_data_i  = $urandom;
    scr_ready_i = ($urandom % 3 != 0);
    mid_valid_i = (midq.size() > 0) && ($urandom % 3 != 0);
    mid_data_i  = (midq.size() > 0) ? midq[0] : 32'h0;
    dst_ready_i = ($urandom % 4 != 0);
    #1;
    rdy_s = scr_ready_i && !load;
    rdy_m = dst_ready_i && !load;
    check(src_ready_o == rdy_s, "R2/R7 src_ready", 32'(src_ready_o), 32'(rdy_s));
    check(scr_valid_o == src_valid_i, "R2 scr_valid", 32'(scr_valid_o), 32'(src_valid_i));
    check(mid_ready_o == rdy_m, "R8/R7 mid_ready", 32'(mid_ready_o), 32'(rdy_m));
    check(dst_valid_o == mid_valid_i, "R8 dst_valid", 32'(dst_valid_o), 32'(mid_valid_i));
    if (src_valid_i)
      check(scr_data_o == (src_data_i ^ tx_k), "R2/R3/R4 scr_data", scr_data_o, src_data_i ^ tx_k);
    if (mid_valid_i)
      check(dst_data_o == (mid_data_i ^ rx_k), "R5 dst_data", dst_data_o, mid_data_i ^ rx_k);
    sf = src_valid_i && rdy_s;
    mf = mid_valid_i && rdy_m;
    if (mf)
      check(dst_data_o == expq[0], "R5 recovered", dst_data_o, expq[0]);
    @(posedge clk);
    if (load) begin
      tx_k = (sd == 0) ? K0 : sd;
      rx_k = tx_k;
    end else begin
      if (sf) begin
        midq.push_back(src_data_i ^ tx_k);
        expq.push_back(src_data_i);
        tx_k = nxt(tx_k);
      end
      if (mf) begin
        void'(midq.pop_front());
        void'(expq.pop_front());
        rx_k = nxt(rx_k);
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && midq.size() > 0; i++) cycle(0, 0, 0);
    check(midq.size() == 0, "R5 drain", 32'(midq.size()), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'(0), 32'(1));
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: fallback key after reset
    src_valid_i = 1'b1;
    src_data_i  = 32'h0;
    scr_ready_i = 1'b0;
    #1;
    check(scr_data_o == K0, "R1 reset key", scr_data_o, K0);
    check(src_ready_o == 1'b0, "R1 ready idle", 32'(src_ready_o), 0);
    src_valid_i = 1'b0;

    for (int i = 0; i < 1500; i++) cycle(1, 0, 0);
    drain();

    // R6: non-zero seed reloads both lanes; R7 checked inside cycle
    cycle(1, 1, 32'hDEAD_BEEF);
    for (int i = 0; i < 1500; i++) cycle(1, 0, 0);
    drain();

    // R6: zero seed becomes fallback
    cycle(1, 1, 32'h0);
    @(negedge clk);
    seed_load_i = 1'b0;
    src_valid_i = 1'b1;
    src_data_i  = 32'h1234_5678;
    scr_ready_i = 1'b0;
    #1;
    check(scr_data_o == (32'h1234_5678 ^ K0), "R6 zero seed", scr_data_o, 32'h1234_5678 ^ K0);
    src_valid_i = 1'b0;

    // R4: long source stall then resume
    for (int i = 0; i < 200; i++) cycle(0, 0, 0);
    for (int i = 0; i < 1500; i++) cycle(1, 0, 0);
    drain();
    finish_run();
  end
endmodule